// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a small fully-associative translation buffer. Every entry holds a tag for a pair of adjacent virtual pages, an address-space identifier and a page-size mask of its own. It also holds two output words, one for the even page of the pair and one for the odd page. Software loads an entry by index through a write port and can read any entry back by index through a combinational read port.

A lookup presents a 32-bit virtual address, the current address-space identifier and a store flag. One cycle later the block returns the physical address, a three-bit cache-attribute code and a fault code. The mask widens the set of ignored tag bits two at a time, from 4 KB pages up to 256 MB pages. The same mask also picks which virtual address bit selects the even or odd page, and which low address bits pass straight through to the physical address.

Because entries are written by index, two entries can match the same lookup. When that happens the lowest-indexed entry wins, and a sticky flag records the event.

Top module: `pairtlb`

## Requirements
- R1: After reset every entry reads back as all zeros, so both halves have V=0, `rsp_valid` and `multi_hit` are 0, and a lookup matching no entry reports miss.
- R2: A write stores the 16-bit mask, the 19-bit tag, the identifier and both output words at `wr_idx`. Read-back of an output word gives bits 31:26 as zero, PFN[19:0] in bits 25:6, the cache attribute in 5:3, D in 2, V in 1 and G in 0.
- R3: `wr_pgmask` bit j (0..15) set to 1 excludes virtual address bit 13+j from the tag compare; address bits 31:29 are always compared. The legal masks are 0x0000, 0x0003, 0x000F, 0x003F, 0x00FF, 0x03FF, 0x0FFF, 0x3FFF and 0xFFFF, for 4 KB to 256 MB pages.
- R4: The odd page is selected by virtual address bit 12+k, where k is the number of mask ones. Physical address bits 11:0, and every bit 12+j whose mask bit j is 1, come from the virtual address. The other bits 12..31 come from PFN bits 0..19.
- R5: A non-global entry matches only when its identifier equals `lk_asid`. A global entry matches under any identifier.
- R6: An entry is global only when G is set in both output words; G in one word alone leaves it non-global.
- R7: A hit on a half whose V is 0 reports fault 2 (invalid), even when the other half of the pair is valid.
- R8: A store that hits a valid half whose D is 0 reports fault 3 (write-protect). A load to that half, or a store to a half with D=1, reports fault 0.
- R9: With no matching entry the fault is 1 (miss). Whenever the fault is not 0, `rsp_pa` and `rsp_cattr` are zero.
- R10: When several entries match, the lowest-indexed one supplies the result and `multi_hit` becomes 1 and stays 1 until reset.
- R11: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid` high, and the response registers are loaded at that edge.
- R12: A lookup in the same cycle as a write to the entry it hits sees the contents from before the write; the next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_pgmask | input | 16 | Ignore mask for virtual address bits 28:13 |
| wr_vtag | input | 19 | Virtual page-pair tag, virtual address bits 31:13 |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_lo_even | input | 32 | Output word for the even page |
| wr_lo_odd | input | 32 | Output word for the odd page |
| rd_idx | input | IDX_W | Entry index to read back |
| rd_pgmask | output | 16 | Stored mask |
| rd_vtag | output | 19 | Stored tag |
| rd_asid | output | ASID_W | Stored identifier |
| rd_lo_even | output | 32 | Stored even output word |
| rd_lo_odd | output | 32 | Stored odd output word |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 32 | Physical address |
| rsp_cattr | output | 3 | Cache-attribute code |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 invalid, 3 write-protect |
| multi_hit | output | 1 | Sticky flag for multiple matching entries |

## Verification
A write to an entry and a lookup that hits that same entry can fall in the same cycle. The bench provokes this by driving both ports on one falling edge, with the new output word carrying a different PFN and cache code. The response must carry the old translation. A second lookup right after must return the new one, which shows that the write landed and that the lookup path was not forwarding the incoming data.

// File: rtl/pairtlb_pkg.sv
package pairtlb_pkg;

  localparam int VA_W   = 32;
  localparam int MASK_W = 16;
  localparam int TAG_W  = 19;
  localparam int PFN_W  = 20;
  localparam int CA_W   = 3;
  localparam int HI_W   = VA_W - 12;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_MISS  = 2'd1,
    FLT_INVAL = 2'd2,
    FLT_WPROT = 2'd3
  } flt_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [CA_W-1:0]  ca;
    logic             wen;
    logic             vld;
    logic             glb;
  } half_t;

  function automatic half_t lo_unpack(input logic [31:0] w);
    half_t h;
    h.pfn = w[25:6];
    h.ca  = w[5:3];
    h.wen = w[2];
    h.vld = w[1];
    h.glb = w[0];
    return h;
  endfunction

  function automatic logic [31:0] lo_pack(input half_t h);
    return {6'b0, h.pfn, h.ca, h.wen, h.vld, h.glb};
  endfunction

endpackage

// File: rtl/pairtlb_entry.sv
module pairtlb_entry
  import pairtlb_pkg::*;
#(
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  half_t             wr_even,
  input  half_t             wr_odd,
  input  logic [HI_W-1:0]   va_hi,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output half_t             sel_half,
  output logic [MASK_W-1:0] mask_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [ASID_W-1:0] asid_q,
  output half_t             even_q,
  output half_t             odd_q
);

  logic [TAG_W-1:0] ign;
  logic [TAG_W-1:0] diff;
  logic             tag_ok;
  logic             asid_ok;
  logic             odd_pick;

  // storage, clock-enabled by the indexed write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      tag_q  <= '0;
      asid_q <= '0;
      even_q <= '0;
      odd_q  <= '0;
    end else if (we) begin
      mask_q <= wr_mask;
      tag_q  <= wr_tag;
      asid_q <= wr_asid;
      even_q <= wr_even;
      odd_q  <= wr_odd;
    end
  end

  // masked compare: top tag bits are never ignored
  always_comb begin
    ign     = {{(TAG_W-MASK_W){1'b0}}, mask_q};
    diff    = va_hi[HI_W-1:1] ^ tag_q;
    tag_ok  = ((diff & ~ign) == '0);
    asid_ok = (even_q.glb & odd_q.glb) | (asid_q == lk_asid);
    hit     = tag_ok & asid_ok;
  end

  // even/odd selector sits just above the page offset for this size
  always_comb begin
    odd_pick = va_hi[0];
    for (int j = 0; j < MASK_W; j++) begin
      if (mask_q[j]) odd_pick = va_hi[j+1];
    end
    sel_half = odd_pick ? odd_q : even_q;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tag_q == $past(wr_tag)) && (asid_q == $past(wr_asid))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(tag_q) && $stable(mask_q)); // R12

endmodule

// File: rtl/pairtlb_pick.sv
module pairtlb_pick #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_vec,
  output logic [N-1:0] grant,
  output logic         any_hit,
  output logic         many_hit
);

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) grant = N'(1) << i;
    end
    any_hit  = |hit_vec;
    many_hit = (hit_vec & (hit_vec - N'(1))) != '0;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R10

  AST_GRANT_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((grant & hit_vec) != '0) && ((hit_vec & (grant - N'(1))) == '0)); // R10

  AST_MANY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    many_hit |-> ($countones(hit_vec) > 1)); // R10

endmodule

// File: rtl/pairtlb.sv
module pairtlb
  import pairtlb_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [15:0]       wr_pgmask,
  input  logic [18:0]       wr_vtag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [31:0]       wr_lo_even,
  input  logic [31:0]       wr_lo_odd,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [15:0]       rd_pgmask,
  output logic [18:0]       rd_vtag,
  output logic [ASID_W-1:0] rd_asid,
  output logic [31:0]       rd_lo_even,
  output logic [31:0]       rd_lo_odd,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              rsp_valid,
  output logic [31:0]       rsp_pa,
  output logic [2:0]        rsp_cattr,
  output logic [1:0]        rsp_fault,
  output logic              multi_hit
);

  // reset: asserted asynchronously, released through two flops
  logic rst_m1, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1  <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_m1  <= 1'b1;
      rst_i_n <= rst_m1;
    end
  end

  logic unused_lo_hi;
  assign unused_lo_hi = ^{wr_lo_even[31:26], wr_lo_odd[31:26]};

  half_t             wr_even_h, wr_odd_h;
  logic [N_ENT-1:0]  hit_vec, grant;
  logic              any_hit, many_hit;
  half_t             e_sel [N_ENT];
  logic [MASK_W-1:0] e_mask [N_ENT];
  logic [TAG_W-1:0]  e_tag [N_ENT];
  logic [ASID_W-1:0] e_asid [N_ENT];
  half_t             e_even [N_ENT];
  half_t             e_odd [N_ENT];

  assign wr_even_h = lo_unpack(wr_lo_even);
  assign wr_odd_h  = lo_unpack(wr_lo_odd);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic we_i;
    assign we_i = wr_en && (wr_idx == IDX_W'(i));
    pairtlb_entry #(.ASID_W(ASID_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .we       (we_i),
      .wr_mask  (wr_pgmask),
      .wr_tag   (wr_vtag),
      .wr_asid  (wr_asid),
      .wr_even  (wr_even_h),
      .wr_odd   (wr_odd_h),
      .va_hi    (lk_va[VA_W-1:12]),
      .lk_asid  (lk_asid),
      .hit      (hit_vec[i]),
      .sel_half (e_sel[i]),
      .mask_q   (e_mask[i]),
      .tag_q    (e_tag[i]),
      .asid_q   (e_asid[i]),
      .even_q   (e_even[i]),
      .odd_q    (e_odd[i])
    );
  end

  pairtlb_pick #(.N(N_ENT)) u_pick (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .hit_vec  (hit_vec),
    .grant    (grant),
    .any_hit  (any_hit),
    .many_hit (many_hit)
  );

  // read-back port
  always_comb begin
    rd_pgmask  = '0;
    rd_vtag    = '0;
    rd_asid    = '0;
    rd_lo_even = '0;
    rd_lo_odd  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_pgmask  = e_mask[i];
        rd_vtag    = e_tag[i];
        rd_asid    = e_asid[i];
        rd_lo_even = lo_pack(e_even[i]);
        rd_lo_odd  = lo_pack(e_odd[i]);
      end
    end
  end

  // winner selection and physical address build
  half_t             win_h;
  logic [MASK_W-1:0] win_m;
  flt_e              flt_c;
  logic [31:0]       pa_c;
  logic [2:0]        ca_c;

  always_comb begin
    win_h = '0;
    win_m = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant[i]) begin
        win_h = win_h | e_sel[i];
        win_m = win_m | e_mask[i];
      end
    end
    if (!any_hit)                    flt_c = FLT_MISS;
    else if (!win_h.vld)             flt_c = FLT_INVAL;
    else if (lk_store && !win_h.wen) flt_c = FLT_WPROT;
    else                             flt_c = FLT_NONE;
    pa_c[11:0]  = lk_va[11:0];
    for (int j = 0; j < MASK_W; j++) begin
      pa_c[12+j] = win_m[j] ? lk_va[12+j] : win_h.pfn[j];
    end
    pa_c[31:28] = win_h.pfn[PFN_W-1:MASK_W];
    ca_c        = win_h.ca;
    if (flt_c != FLT_NONE) begin
      pa_c = '0;
      ca_c = '0;
    end
  end

  // response registers: next-state then register process
  logic        vld_q, vld_d;
  logic [31:0] pa_q;
  logic [2:0]  ca_q;
  flt_e        flt_q;
  logic        mh_q, mh_d;

  always_comb begin
    vld_d = lk_valid;
    mh_d  = mh_q | (lk_valid & many_hit);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= 1'b0;
      mh_q  <= 1'b0;
      pa_q  <= '0;
      ca_q  <= '0;
      flt_q <= FLT_NONE;
    end else begin
      vld_q <= vld_d;
      mh_q  <= mh_d;
      if (lk_valid) begin
        pa_q  <= pa_c;
        ca_q  <= ca_c;
        flt_q <= flt_c;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_pa    = pa_q;
  assign rsp_cattr = ca_q;
  assign rsp_fault = flt_q;
  assign multi_hit = mh_q;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    lk_valid |=> rsp_valid); // R11

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !lk_valid |=> !rsp_valid); // R11

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0 && rsp_cattr == '0)); // R9

  AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lk_valid && !(|hit_vec)) |=> (rsp_fault == 2'd1)); // R9

  AST_MULTI_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    multi_hit |=> multi_hit); // R10

  AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_lo_even[31:26] == '0) && (rd_lo_odd[31:26] == '0)); // R2

endmodule

// File: tb/pairtlb_bench.sv
`timescale 1ns/1ps
module pairtlb_bench;

  localparam int N_ENT  = 16;
  localparam int ASID_W = 8;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [15:0]       wr_pgmask;
  logic [18:0]       wr_vtag;
  logic [ASID_W-1:0] wr_asid;
  logic [31:0]       wr_lo_even, wr_lo_odd;
  logic [IDX_W-1:0]  rd_idx;
  logic [15:0]       rd_pgmask;
  logic [18:0]       rd_vtag;
  logic [ASID_W-1:0] rd_asid;
  logic [31:0]       rd_lo_even, rd_lo_odd;
  logic              lk_valid;
  logic [31:0]       lk_va;
  logic [ASID_W-1:0] lk_asid;
  logic              lk_store;
  logic              rsp_valid;
  logic [31:0]       rsp_pa;
  logic [2:0]        rsp_cattr;
  logic [1:0]        rsp_fault;
  logic              multi_hit;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  pairtlb #(.N_ENT(N_ENT), .ASID_W(ASID_W)) u_pairtlb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_pgmask(wr_pgmask), .wr_vtag(wr_vtag),
    .wr_asid(wr_asid), .wr_lo_even(wr_lo_even), .wr_lo_odd(wr_lo_odd),
    .rd_idx(rd_idx), .rd_pgmask(rd_pgmask), .rd_vtag(rd_vtag), .rd_asid(rd_asid),
    .rd_lo_even(rd_lo_even), .rd_lo_odd(rd_lo_odd),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_store(lk_store),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_cattr(rsp_cattr),
    .rsp_fault(rsp_fault), .multi_hit(multi_hit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL R11 watchdog expired: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] mk_lo(input logic [19:0] pfn, input logic [2:0] c,
                                        input logic d, input logic v, input logic g);
    return {6'b0, pfn, c, d, v, g};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int idx, input logic [15:0] m, input logic [18:0] t,
                          input logic [7:0] a, input logic [31:0] e, input logic [31:0] o);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_pgmask = m; wr_vtag = t;
    wr_asid = a; wr_lo_even = e; wr_lo_odd = o;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_look(input logic [31:0] va, input logic [7:0] a, input logic st);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = a; lk_store = st;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        st;
    logic [1:0]  flt;
    logic [31:0] pa;
    logic [2:0]  ca;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0002_0ABC, 8'd5, 1'b0, 2'd0, 32'h0011_1ABC, 3'd3, 8'd4},
    '{32'h0002_0ABC, 8'd5, 1'b1, 2'd0, 32'h0011_1ABC, 3'd3, 8'd8},
    '{32'h0002_1ABC, 8'd5, 1'b0, 2'd0, 32'h0022_2ABC, 3'd2, 8'd4},
    '{32'h0002_1ABC, 8'd5, 1'b1, 2'd3, 32'h0000_0000, 3'd0, 8'd8},
    '{32'h0002_0ABC, 8'd6, 1'b0, 2'd1, 32'h0000_0000, 3'd0, 8'd5},
    '{32'h4000_1234, 8'd9, 1'b0, 2'd0, 32'h1234_1234, 3'd5, 8'd3},
    '{32'h4000_2000, 8'd9, 1'b1, 2'd0, 32'h1234_2000, 3'd5, 8'd3},
    '{32'h4000_5234, 8'd9, 1'b0, 2'd2, 32'h0000_0000, 3'd0, 8'd7},
    '{32'h1003_4567, 8'd7, 1'b0, 2'd0, 32'hAAA3_4567, 3'd3, 8'd4},
    '{32'h1013_4567, 8'd7, 1'b0, 2'd0, 32'h5553_4567, 3'd4, 8'd4},
    '{32'h1003_4567, 8'd8, 1'b0, 2'd1, 32'h0000_0000, 3'd0, 8'd6},
    '{32'h6123_4567, 8'd2, 1'b1, 2'd0, 32'hF123_4567, 3'd7, 8'd3},
    '{32'h7123_4567, 8'd2, 1'b0, 2'd2, 32'h0000_0000, 3'd0, 8'd7},
    '{32'h9000_0000, 8'd5, 1'b0, 2'd1, 32'h0000_0000, 3'd0, 8'd9}
  };

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_pgmask = '0; wr_vtag = '0;
    wr_asid = '0; wr_lo_even = '0; wr_lo_odd = '0; rd_idx = 4'd4;
    lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_store = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "multi_hit after reset", 32'(multi_hit), 32'd0);
    chk("R1", "entry4 even word", rd_lo_even, 32'd0);
    chk("R1", "entry4 odd word", rd_lo_odd, 32'd0);
    chk("R1", "entry4 tag", 32'(rd_vtag), 32'd0);
    do_look(32'h8000_0000, 8'd3, 1'b0);
    chk("R1", "fault with empty buffer", 32'(rsp_fault), 32'd1);
    chk("R11", "rsp_valid after lookup", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    chk("R11", "rsp_valid idle cycle", 32'(rsp_valid), 32'd0);

    // load entries
    do_write(0, 16'h0000, 19'h00010, 8'd5, mk_lo(20'h00111, 3'd3, 1'b1, 1'b1, 1'b0),
             mk_lo(20'h00222, 3'd2, 1'b0, 1'b1, 1'b0));
    do_write(1, 16'h0003, 19'h20000, 8'd1, mk_lo(20'h12343, 3'd5, 1'b1, 1'b1, 1'b1),
             mk_lo(20'h00000, 3'd0, 1'b0, 1'b0, 1'b1));
    do_write(2, 16'h00FF, 19'h08000, 8'd7, mk_lo(20'hAAAAA, 3'd3, 1'b1, 1'b1, 1'b1),
             mk_lo(20'h55555, 3'd4, 1'b1, 1'b1, 1'b0));
    do_write(3, 16'hFFFF, 19'h30000, 8'd0, mk_lo(20'hF0000, 3'd7, 1'b1, 1'b1, 1'b1),
             mk_lo(20'h00000, 3'd0, 1'b0, 1'b0, 1'b1));
    do_write(9, 16'h000F, 19'h7FFFF, 8'hAB, 32'hFFFF_FFFF, 32'h0000_0000);

    // R2 read-back
    @(negedge clk); rd_idx = 4'd9; #1;
    chk("R2", "mask readback", 32'(rd_pgmask), 32'h000F);
    chk("R2", "tag readback", 32'(rd_vtag), 32'h7FFFF);
    chk("R2", "asid readback", 32'(rd_asid), 32'hAB);
    chk("R2", "even word top bits cleared", rd_lo_even, 32'h03FF_FFFF);
    chk("R2", "odd word", rd_lo_odd, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      do_look(VEC[k].va, VEC[k].asid, VEC[k].st);
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vec%0d fault", k), 32'(rsp_fault), 32'(VEC[k].flt));
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vec%0d pa", k), rsp_pa, VEC[k].pa);
      chk($sformatf("R%0d", VEC[k].req), $sformatf("vec%0d cattr", k), 32'(rsp_cattr), 32'(VEC[k].ca));
    end
    chk("R10", "no multi-hit yet", 32'(multi_hit), 32'd0);

    // R10 duplicates: lowest index wins, flag sticks
    do_write(7, 16'h0000, 19'h04000, 8'd1, mk_lo(20'h0CAFE, 3'd6, 1'b1, 1'b1, 1'b0), 32'h0);
    do_write(5, 16'h0000, 19'h04000, 8'd1, mk_lo(20'h0BEEF, 3'd1, 1'b1, 1'b1, 1'b0), 32'h0);
    do_look(32'h0800_0123, 8'd1, 1'b0);
    chk("R10", "lowest entry pa", rsp_pa, 32'h0BEE_F123);
    chk("R10", "lowest entry cattr", 32'(rsp_cattr), 32'd1);
    chk("R10", "multi_hit set", 32'(multi_hit), 32'd1);
    do_look(32'h0002_0ABC, 8'd5, 1'b0);
    chk("R10", "multi_hit sticky", 32'(multi_hit), 32'd1);

    // R12 write and lookup of the same entry in one cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd0; wr_pgmask = 16'h0000; wr_vtag = 19'h00010; wr_asid = 8'd5;
    wr_lo_even = mk_lo(20'h00777, 3'd6, 1'b1, 1'b1, 1'b0);
    wr_lo_odd  = mk_lo(20'h00222, 3'd2, 1'b0, 1'b1, 1'b0);
    lk_valid = 1'b1; lk_va = 32'h0002_0ABC; lk_asid = 8'd5; lk_store = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R12", "same-cycle lookup sees old pa", rsp_pa, 32'h0011_1ABC);
    chk("R12", "same-cycle lookup sees old cattr", 32'(rsp_cattr), 32'd3);
    do_look(32'h0002_0ABC, 8'd5, 1'b0);
    chk("R12", "next lookup sees new pa", rsp_pa, 32'h0077_7ABC);
    chk("R12", "next lookup sees new cattr", 32'(rsp_cattr), 32'd6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule